// File: doc/BRIEF.md
# Counter Timebase with Protected Mode Register

This block drives a 16-bit counter/timer from one of several clock sources and holds the 8-bit mode register that configures it. Each cycle it decides whether the counter advances, using a single-cycle count strobe. The strobe can come from three places:

- a divided system clock;
- a timer overflow pulse;
- a synchronised external input, counted either on its falling edges or on its rising edges divided by eight.

When the counter wraps past its maximum, a sticky overflow flag is set. That flag is gated by an enable bit to form the interrupt request.

The same register holds a watchdog enable, which is set out of reset. While the watchdog enable is set, the register ignores every write except one that clears the enable itself. A lock bit makes the enable permanent until the next reset. The idle-hold bit freezes counting while the processor reports idle.

Register layout (read and write): bit 7 idle hold, bit 6 watchdog enable, bit 5 watchdog lock, bit 4 unused, bits 3:1 source select, bit 0 overflow interrupt enable.

Top module: `ctr_timebase`

## Requirements
- R1: After reset the register reads 0x40, the counter reads 0 and the overflow flag and interrupt request are 0.
- R2: While bit 6 reads 1, a write changes no bit, except that a write with bit 6 = 0 and the lock clear clears bit 6 alone. The other fields of that write are dropped and need a second write.
- R3: Once bit 5 is set, it and bit 6 can no longer be cleared by writes until reset.
- R4: Bit 4 always reads 0, whatever was written to it.
- R5: Source select 000 advances the counter once every 12 system clocks. The divider restarts from zero when the source select changes.
- R6: Source select 001 advances the counter once every 4 system clocks. The divider restarts from zero when the source select changes.
- R7: Source select 010 advances the counter once per clock in which the timer overflow input is high.
- R8: Source select 011 advances the counter once per high-to-low transition of the external count input, after two-flop synchronisation. Inputs change at most once every 4 clocks.
- R9: Source select 100 advances the counter on every clock.
- R10: Source select 101 advances the counter once per 8 rising edges of the synchronised external clock input.
- R11: Source selects 110 and 111 never advance the counter.
- R12: The counter wraps from 0xFFFF to 0x0000 and sets the overflow flag in that same edge. The flag stays set until the clear input is pulsed.
- R13: The interrupt request is high exactly when the overflow flag is set and bit 0 is 1.
- R14: With bit 7 = 1 and the idle input high, the counter and flag hold. With bit 7 = 0, idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| cpu_idle | input | 1 | Processor idle indication |
| t0_ovf | input | 1 | Timer overflow pulse source |
| ext_cnt_in | input | 1 | External count input, falling edges counted |
| ext_clk_in | input | 1 | External clock input, divided by 8 |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Watchdog enable |
| tick | output | 1 | Count strobe actually applied this cycle |

## Verification
Counting is measured over windows, as the change of the counter value.

- **Divided sources:** the window is one clock short of a multiple of the divisor, then exactly that multiple. This shows the divide ratio and the divider restart after a source change.
- **Edge sources:** bursts of edges show one count per edge, or per eight edges, and no counts from the synchronisation delay.
- **Reserved codes and idle hold:** the same windows show that nothing is counted.
- **Register writes:** a sequence of writes separates the protected state, the unlocked clear and the locked state.
- **Wrap:** a long run to 0xFFFF exercises the wrap, the sticky flag, the interrupt gating and the clear.

// File: rtl/ctr_timebase.sv
module ctr_timebase #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int DIV_EXT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             cpu_idle,
  input  logic             t0_ovf,
  input  logic             ext_cnt_in,
  input  logic             ext_clk_in,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdog_en,
  output logic             tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? ((DIV_SLOW > DIV_EXT) ? DIV_SLOW : DIV_EXT)
                                                 : ((DIV_FAST > DIV_EXT) ? DIV_FAST : DIV_EXT);
  localparam int PRE_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic       idle_hold, wd_lock, ovf_ie;
  logic [2:0] src;
  logic       accept;

  assign accept = wr_en && !wdog_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_hold <= 1'b0;
      wdog_en   <= 1'b1;
      wd_lock   <= 1'b0;
      src       <= 3'd0;
      ovf_ie    <= 1'b0;
    end else if (wr_en) begin
      if (wdog_en) begin
        if (!wr_data[6] && !wd_lock) wdog_en <= 1'b0;
      end else begin
        idle_hold <= wr_data[7];
        wdog_en   <= wr_data[6];
        wd_lock   <= wd_lock | wr_data[5];
        src       <= wr_data[3:1];
        ovf_ie    <= wr_data[0];
      end
    end
  end

  assign rd_data = {idle_hold, wdog_en, wd_lock, 1'b0, src, ovf_ie};

  logic [2:0] cin_s, ckin_s;
  logic       cnt_fall, ck_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cin_s  <= 3'b000;
      ckin_s <= 3'b000;
    end else begin
      cin_s  <= {cin_s[1:0], ext_cnt_in};
      ckin_s <= {ckin_s[1:0], ext_clk_in};
    end
  end

  assign cnt_fall = cin_s[2] & ~cin_s[1];
  assign ck_rise  = ckin_s[1] & ~ckin_s[2];

  logic [PRE_W-1:0] pre, div_lim;
  logic             pre_adv, pre_hit;

  assign div_lim = (src == 3'd0) ? PRE_W'(DIV_SLOW - 1) :
                   (src == 3'd1) ? PRE_W'(DIV_FAST - 1) : PRE_W'(DIV_EXT - 1);
  assign pre_adv = (src == 3'd5) ? ck_rise : 1'b1;
  assign pre_hit = pre_adv && (pre == div_lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                               pre <= '0;
    else if (accept && wr_data[3:1] != src)   pre <= '0;
    else if (pre_hit)                         pre <= '0;
    else if (pre_adv)                         pre <= pre + 1'b1;
  end

  logic raw;
  always_comb begin
    case (src)
      3'd0, 3'd1: raw = pre_hit;
      3'd2:       raw = t0_ovf;
      3'd3:       raw = cnt_fall;
      3'd4:       raw = 1'b1;
      3'd5:       raw = pre_hit;
      default:    raw = 1'b0;
    endcase
  end

  assign tick = raw && !(idle_hold && cpu_idle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (tick) count_q <= count_q + 1'b1;
      if (tick && &count_q) ovf_flag <= 1'b1;
      else if (ovf_clr)     ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag && ovf_ie;
endmodule

module ctr_timebase_chk #(parameter int CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       rd_data,
  input logic             cpu_idle,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_flag,
  input logic             irq,
  input logic             wdog_en
);
  assert_protect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en && wr_en) |=> (rd_data[7] == $past(rd_data[7]) && rd_data[5:0] == $past(rd_data[5:0])));
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en && rd_data[5]) |=> (wdog_en && rd_data[5]));
  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n) rd_data[4] == 1'b0);
  assert_reserved_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:2] == 2'b11) |=> $stable(count_q));
  assert_step_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == CNT_W'($past(count_q) + 1'b1)));
  assert_wrap_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && $past(count_q) == '1) |-> ovf_flag);
  assert_irq_needs_flag_R13: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ovf_flag);
  assert_idle_freeze_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && cpu_idle) |=> $stable(count_q));
endmodule

bind ctr_timebase ctr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .cpu_idle(cpu_idle),
  .count_q(count_q), .ovf_flag(ovf_flag), .irq(irq), .wdog_en(wdog_en)
);

// File: tb/test_ctr_timebase.sv
module test_ctr_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        cpu_idle = 1'b0, t0_ovf = 1'b0, ext_cnt_in = 1'b0, ext_clk_in = 1'b0, ovf_clr = 1'b0;
  logic [15:0] count_q;
  logic        ovf_flag, irq, wdog_en, tick;
  int          checks = 0, errors = 0;
  logic [15:0] snap;

  always #4 clk = ~clk;

  ctr_timebase i_ctr_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cpu_idle(cpu_idle), .t0_ovf(t0_ovf), .ext_cnt_in(ext_cnt_in), .ext_clk_in(ext_clk_in),
    .ovf_clr(ovf_clr), .count_q(count_q), .ovf_flag(ovf_flag), .irq(irq),
    .wdog_en(wdog_en), .tick(tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 reg", rd_data, 8'h40);
    chk("R1 count", count_q, 0);
    chk("R1 flag", {ovf_flag, irq}, 0);

    // R2 protected writes
    wr(8'hC3);
    chk("R2 blocked", rd_data, 8'h40);
    wr(8'hBF);
    chk("R2 only enable cleared", rd_data, 8'h00);
    wr(8'h9F);
    chk("R4 unused reads zero", rd_data, 8'h8F);
    wr(8'h00);

    // R5 R6 R9 divided and direct sweeps
    for (int s = 0; s < 3; s++) begin
      automatic int sel = (s == 2) ? 4 : s;
      automatic int dv  = (s == 0) ? 12 : (s == 1) ? 4 : 1;
      for (int n = 1; n <= 3; n++) begin
        wr(8'h0C);
        wr(8'(sel << 1));
        snap = count_q;
        wait_n(dv * n - 1);
        chk(s == 0 ? "R5 short" : s == 1 ? "R6 short" : "R9 short", count_q - snap, n - 1);
        wait_n(1);
        chk(s == 0 ? "R5 full" : s == 1 ? "R6 full" : "R9 full", count_q - snap, n);
      end
    end

    // R7 timer overflow pulses
    wr(8'h04);
    snap = count_q;
    for (int k = 0; k < 5; k++) begin
      t0_ovf = 1'b1; wait_n(1); t0_ovf = 1'b0; wait_n(2);
    end
    chk("R7 pulses", count_q - snap, 5);

    // R8 falling edges on external count input
    ext_cnt_in = 1'b1;
    wait_n(5);
    wr(8'h06);
    snap = count_q;
    for (int k = 0; k < 6; k++) begin
      ext_cnt_in = 1'b0; wait_n(4); ext_cnt_in = 1'b1; wait_n(4);
    end
    wait_n(5);
    chk("R8 falls", count_q - snap, 6);

    // R10 external clock divided by eight
    wr(8'h0A);
    snap = count_q;
    for (int k = 0; k < 23; k++) begin
      ext_clk_in = 1'b1; wait_n(2); ext_clk_in = 1'b0; wait_n(2);
    end
    wait_n(5);
    chk("R10 23 edges", count_q - snap, 2);
    ext_clk_in = 1'b1; wait_n(2); ext_clk_in = 1'b0; wait_n(6);
    chk("R10 24 edges", count_q - snap, 3);

    // R11 reserved codes
    for (int c = 6; c <= 7; c++) begin
      wr(8'(c << 1));
      snap = count_q;
      t0_ovf = 1'b1; wait_n(40); t0_ovf = 1'b0;
      chk("R11 reserved", count_q - snap, 0);
    end

    // R14 idle hold
    wr(8'h88);
    cpu_idle = 1'b1; snap = count_q;
    wait_n(10);
    chk("R14 held", count_q - snap, 0);
    cpu_idle = 1'b0; snap = count_q;
    wait_n(10);
    chk("R14 resumes", count_q - snap, 10);
    wr(8'h08);
    cpu_idle = 1'b1; snap = count_q;
    wait_n(10);
    chk("R14 idle ignored", count_q - snap, 10);
    cpu_idle = 1'b0;

    // R12 R13 wrap, sticky flag, interrupt gating
    while (count_q != 16'hFFFE) @(negedge clk);
    chk("R12 before wrap", ovf_flag, 0);
    wait_n(1);
    chk("R12 at max", {count_q, ovf_flag}, {16'hFFFF, 1'b0});
    wait_n(1);
    chk("R12 wrapped", {count_q, ovf_flag}, {16'h0000, 1'b1});
    chk("R13 masked", irq, 0);
    wait_n(20);
    chk("R12 sticky", ovf_flag, 1);
    wr(8'h09);
    chk("R13 enabled", irq, 1);
    ovf_clr = 1'b1; wait_n(1); ovf_clr = 1'b0;
    chk("R12 cleared", {ovf_flag, irq}, 0);

    // R3 lock
    wr(8'h60);
    chk("R3 locked set", rd_data, 8'h60);
    wr(8'h00);
    chk("R3 clear refused", rd_data, 8'h60);
    wr(8'h1F);
    chk("R3 still locked", wdog_en, 1);
    do_reset();
    chk("R3 reset unlocks", rd_data, 8'h40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule